// File: doc/BRIEF.md
# Chip Identifier Readout Registers

This block is a small peripheral on a 32-bit register bus. It holds a fixed 128-bit device identifier, which is set by a parameter. Software cannot read the identifier directly. Instead, it writes a control word that carries three things: a byte offset in its upper half, a trigger bit, and at least one bit of a lock pattern. The block then copies four consecutive identifier bytes into a read-only key register, assembled most-significant byte first. Software reads that register afterwards.

Only two word locations are decoded inside a 1 KiB window:

- the control register at 0x40;
- the key register at 0x60.

Every other location reads as zero and ignores writes. Accesses that are not full 32-bit accesses are ignored. Read data is registered and appears one cycle after the read strobe.

A fetch is refused when the offset would run past the end of the identifier. In that case the key register keeps whatever it held before.

Top module: `chipid_regs`

## Requirements
- R1: After reset, the control register and the key register read back as 0x00000000, and the read data output is 0.
- R2: A full-word write to 0x40 stores the written value, except that bit 1 (the trigger) is cleared. A later read of 0x40 returns that stored value.
- R3: A fetch happens only on a write to 0x40 whose value has bit 1 set and also has at least one bit of the mask 0x0000AC00 set. With either condition missing, the key register keeps its value.
- R4: On a fetch, the offset is bits [31:16] of the written value. The key register becomes identifier bytes off, off+1, off+2 and off+3, with byte off in bits [31:24]. Identifier byte 0 is bits [127:120] of the DEV_ID parameter.
- R5: A fetch with an offset greater than 12 (the identifier size minus four) is skipped, and the key register keeps its old value.
- R6: The key register at 0x60 is read-only. A write there changes neither register.
- R7: A read of any address other than 0x40 or 0x60 returns zero. A write to such an address changes neither register.
- R8: When bus_word is 0 (not a full 32-bit access), a write has no effect and a read returns zero.
- R9: bus_rdata is updated on the clock edge that samples a read strobe, and it holds while no access is made. A read in the cycle right after a fetching write already returns the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access; 0 = narrower access (ignored) |
| bus_addr | input | 10 | Byte address inside the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The fetch is tried at every offset from 0 to 15. Each offset is written once with a full lock pattern and the trigger, and again with the trigger alone. This separates correct byte ordering, the bounds limit at 12 and the lock qualification from each other. Single lock bits in isolation, and lock bits without the trigger, show that any one bit of the mask qualifies but the trigger is still required. Control words with random-looking upper bits confirm that only bit 1 is cleared. Writes to the key address, to undecoded addresses and narrow accesses are each followed by readbacks of both registers, which expose any state they might have disturbed.

// File: rtl/chipid_pkg.sv
package chipid_pkg;

  localparam int unsigned CTRL_OFS  = 32'h40;
  localparam int unsigned KEY_OFS   = 32'h60;
  localparam int unsigned TRIG_BIT  = 1;
  localparam int unsigned OFF_LSB   = 16;
  localparam logic [15:0] LOCK_MASK = 16'hAC00;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_KEY  = 2'd2
  } regsel_e;

  typedef struct packed {
    logic    rd;
    logic    wr;
    regsel_e sel;
  } acc_s;

endpackage

// File: rtl/chipid_addr_dec.sv
module chipid_addr_dec
  import chipid_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_s              acc
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_OFS);

  always_comb begin
    acc.rd  = bus_sel && !bus_wr;
    acc.wr  = bus_sel && bus_wr && bus_word;
    acc.sel = SEL_NONE;
    if (bus_sel && bus_word) begin
      if (bus_addr == CTRL_A)     acc.sel = SEL_CTRL;
      else if (bus_addr == KEY_A) acc.sel = SEL_KEY;
    end
  end

endmodule

// File: rtl/chipid_ctrl_reg.sv
module chipid_ctrl_reg
  import chipid_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned OFF_W = DATA_W - OFF_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              fetch_req,
  output logic [OFF_W-1:0]  fetch_off
);

  logic [DATA_W-1:0] ctrl_d;
  logic [DATA_W-1:0] trig_clr;
  logic              lock_hit;

  always_comb begin
    trig_clr           = '1;
    trig_clr[TRIG_BIT] = 1'b0;
    lock_hit           = |(wdata[15:0] & LOCK_MASK);
    fetch_req          = wr_en && lock_hit && wdata[TRIG_BIT];
    fetch_off          = wdata[DATA_W-1:OFF_LSB];
    ctrl_d             = ctrl_q;
    if (wr_en) ctrl_d = wdata & trig_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/chipid_key_fetch.sv
module chipid_key_fetch #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned ID_BYTES = 16,
  parameter logic [ID_BYTES*8-1:0] DEV_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [OFF_W-1:0]  fetch_off,
  output logic [DATA_W-1:0] key_q
);

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned OFF_MAX = ID_BYTES - LANES;

  logic [DATA_W-1:0] gathered;
  logic [DATA_W-1:0] key_d;
  logic              in_range;
  logic              load_en;

  function automatic logic [7:0] id_byte(input int unsigned idx);
    if (idx < ID_BYTES) return DEV_ID[(ID_BYTES-1-idx)*8 +: 8];
    return 8'h00;
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb
      gathered[DATA_W-1-8*k -: 8] = id_byte(int'(fetch_off) + k);
  end

  always_comb begin
    in_range = 32'(fetch_off) <= OFF_MAX;
    load_en  = fetch_req && in_range;
    key_d    = load_en ? gathered : key_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else if (load_en) key_q <= key_d;
  end

endmodule

// File: rtl/chipid_regs.sv
module chipid_regs
  import chipid_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_BYTES = 16,
  parameter logic [ID_BYTES*8-1:0] DEV_ID = 128'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned OFF_W = DATA_W - OFF_LSB;

  acc_s              acc;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] key_q;
  logic              fetch_req;
  logic [OFF_W-1:0]  fetch_off;
  logic              ctrl_we;
  logic [DATA_W-1:0] rdata_d;

  chipid_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .acc      (acc)
  );

  assign ctrl_we = acc.wr && (acc.sel == SEL_CTRL);

  chipid_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_we),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .fetch_req (fetch_req),
    .fetch_off (fetch_off)
  );

  chipid_key_fetch #(
    .DATA_W   (DATA_W),
    .OFF_W    (OFF_W),
    .ID_BYTES (ID_BYTES),
    .DEV_ID   (DEV_ID)
  ) u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .fetch_off (fetch_off),
    .key_q     (key_q)
  );

  always_comb begin
    unique case (acc.sel)
      SEL_CTRL: rdata_d = ctrl_q;
      SEL_KEY:  rdata_d = key_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (acc.rd) bus_rdata <= rdata_d;
  end

endmodule

// File: rtl/chipid_regs_chk.sv
module chipid_regs_chk #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] key_q
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(32'h40);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(32'h60);
  localparam int unsigned MAX_OFF      = ID_BYTES - DATA_W / 8;

  logic wr_ctrl, wr_key, rd_other;
  assign wr_ctrl  = bus_sel && bus_wr && bus_word && bus_addr == A_CTRL;
  assign wr_key   = bus_sel && bus_wr && bus_word && bus_addr == A_KEY;
  assign rd_other = bus_sel && !bus_wr && bus_word &&
                    bus_addr != A_CTRL && bus_addr != A_KEY;

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == ($past(bus_wdata) & ~32'h2));

  // R3
  no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (bus_wdata[15:0] & 16'hAC00) == 16'h0) |=> $stable(key_q));

  // R3
  no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[1]) |=> $stable(key_q));

  // R5
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && 32'(bus_wdata[31:16]) > MAX_OFF) |=> $stable(key_q));

  // R6
  key_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key |=> ($stable(key_q) && $stable(ctrl_q)));

  // R7
  undec_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |=> bus_rdata == '0);

  // R8
  narrow_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_word) |=> bus_rdata == '0);

  // R8
  narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_word) |=> ($stable(ctrl_q) && $stable(key_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(bus_rdata));

endmodule

bind chipid_regs chipid_regs_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .ID_BYTES (ID_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_word  (bus_word),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ctrl_q    (ctrl_q),
  .key_q     (key_q)
);

// File: tb/chipid_regs_tb_top.sv
module chipid_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] ID_VAL = 128'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_word;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  string cur_tag = "R1";
  string exp_tag = "R1";

  byte unsigned id_b[16];
  logic [31:0] m_ctrl, m_key, m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  chipid_regs #(.DEV_ID(ID_VAL)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial begin
    logic [127:0] t;
    t = ID_VAL;
    for (int i = 15; i >= 0; i--) begin
      id_b[i] = t[7:0];
      t = t >> 8;
    end
  end

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_key = 0; m_rdata = 0;
    end else if (bus_sel) begin
      if (!bus_wr) begin
        exp_tag = cur_tag;
        if (!bus_word)                m_rdata = 0;
        else if (bus_addr == 10'h040) m_rdata = m_ctrl;
        else if (bus_addr == 10'h060) m_rdata = m_key;
        else                          m_rdata = 0;
      end else if (bus_word && bus_addr == 10'h040) begin
        int off;
        off = bus_wdata[31:16];
        m_ctrl = bus_wdata & 32'hFFFF_FFFD;
        if (bus_wdata[1] && (bus_wdata & 32'h0000_AC00) != 0 && off <= 12)
          m_key = {id_b[off], id_b[off+1], id_b[off+2], id_b[off+3]};
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    total++;
    if (bus_rdata !== m_rdata) begin
      bad++;
      $display("FAIL %s: rdata actual=%h expected=%h", exp_tag, bus_rdata, m_rdata);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic op(input string tag, input logic wr, input logic word,
                    input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    cur_tag = tag;
    bus_sel = 1'b1; bus_wr = wr; bus_word = word; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b1;
  endtask

  task automatic rd_both(input string tag);
    op(tag, 1'b0, 1'b1, 10'h040, 32'h0);
    op(tag, 1'b0, 1'b1, 10'h060, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_word = 1; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 direct check of reset state
    total++;
    if (bus_rdata !== 32'h0) begin
      bad++;
      $display("FAIL R1: rdata actual=%h expected=00000000", bus_rdata);
    end
    rd_both("R1");

    // R2: trigger cleared, other bits kept (offset too large: no fetch)
    op("R2", 1'b1, 1'b1, 10'h040, 32'h1234_5676);
    op("R2", 1'b0, 1'b1, 10'h040, 32'h0);
    op("R2", 1'b1, 1'b1, 10'h040, 32'hFFFF_53FF);
    rd_both("R2");

    // R4 / R5 / R9: all offsets with full lock, read right after write
    for (int o = 0; o < 16; o++) begin
      op((o > 12) ? "R5" : "R4", 1'b1, 1'b1, 10'h040, (o << 16) | 32'h0000_AC02);
      op("R9", 1'b0, 1'b1, 10'h060, 32'h0);
      // R3: trigger without lock
      op("R3", 1'b1, 1'b1, 10'h040, (((o + 3) % 13) << 16) | 32'h0000_0002);
      op("R3", 1'b0, 1'b1, 10'h060, 32'h0);
    end
    // R3: lock without trigger, then single lock bits
    op("R3", 1'b1, 1'b1, 10'h040, 32'h0005_AC00);
    op("R3", 1'b0, 1'b1, 10'h060, 32'h0);
    op("R3", 1'b1, 1'b1, 10'h040, 32'h0002_0402);
    op("R3", 1'b0, 1'b1, 10'h060, 32'h0);
    op("R3", 1'b1, 1'b1, 10'h040, 32'h0007_0802);
    op("R3", 1'b0, 1'b1, 10'h060, 32'h0);
    op("R3", 1'b1, 1'b1, 10'h040, 32'h000B_2002);
    op("R3", 1'b0, 1'b1, 10'h060, 32'h0);
    op("R3", 1'b1, 1'b1, 10'h040, 32'h0009_8002);
    rd_both("R3");

    // R6: write to key register
    op("R6", 1'b1, 1'b1, 10'h060, 32'hDEAD_BEEF);
    rd_both("R6");

    // R7: undecoded addresses
    op("R7", 1'b0, 1'b1, 10'h000, 32'h0);
    op("R7", 1'b0, 1'b1, 10'h044, 32'h0);
    op("R7", 1'b0, 1'b1, 10'h3FC, 32'h0);
    op("R7", 1'b1, 1'b1, 10'h100, 32'h0001_AC02);
    op("R7", 1'b1, 1'b1, 10'h041, 32'h0000_AC02);
    rd_both("R7");

    // R8: narrow accesses
    op("R8", 1'b1, 1'b0, 10'h040, 32'h0004_AC02);
    rd_both("R8");
    op("R8", 1'b0, 1'b0, 10'h040, 32'h0);
    op("R8", 1'b0, 1'b0, 10'h060, 32'h0);

    // R9: holds while idle
    op("R9", 1'b0, 1'b1, 10'h060, 32'h0);
    cur_tag = "R9";
    repeat (4) idle();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule